// File: doc/BRIEF.md
# Tree Bubble Sorter

This block sorts a batch of P unsigned values held in the leaves of a binary tree of cells. A load strobe copies the P-element input vector into the leaves and empties every inner cell. From then on two flows run at once. Upward, each inner cell keeps one slot per child and pulls the smaller candidate from below into whichever slot is empty, so the root releases the elements one at a time, smallest first. Downward, each released element carries its rank through a pipeline of steering stages. Each stage sends the element toward the left subtree when the rank fits within that subtree's leaf count. Otherwise it sends it right and subtracts the left count from the rank.

When the last element has reached its leaf position, a one-cycle done strobe marks the sorted vector as complete. The vector then holds until a later load overwrites it. The whole sort takes a number of cycles linear in P, because every element crosses the single link out of the root.

Top module: `tree_bubble_sorter`

## Requirements
- R1: After reset, done_o is 0 and sorted_o is all zeros.
- R2: After a load, sorted_o holds the loaded values in nondescending order. Element i occupies bits [i*W +: W], and element 0 is the smallest.
- R3: Duplicate values are kept. The output is the same multiset as the input: nothing is lost and nothing is repeated. The root releases at most P elements per load.
- R4: done_o is high for exactly one cycle per completed sort, and only once all P positions have been written.
- R5: After done_o, sorted_o does not change until the next load.
- R6: A load issued while a sort is in progress abandons that sort. Only the newest vector produces a done_o and a result.
- R7: The value 0 and the all-ones value sort correctly. An empty slot never competes as a value, even against the all-ones value.
- R8: done_o rises no later than 4*P + 2*log2(P) + 8 cycles after the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| load_i | input | 1 | Starts a sort with data_i; restarts any sort in progress |
| data_i | input | P*W | P unsigned values, element i at bits [i*W +: W] |
| done_o | output | 1 | One-cycle strobe when sorted_o is complete |
| sorted_o | output | P*W | Sorted values, smallest at element 0 |

## Verification
The bench feeds several kinds of input: ascending, descending, all-equal, heavily duplicated vectors, and vectors that contain both 0 and the all-ones value. Each kind breaks a different kind of faulty design. Treating an empty slot as a value would place a phantom maximum or lose the all-ones entries. A cell that forwarded before its other side was known would emit elements out of order and leave the leaves unsorted. Faulty rank reduction on right turns would collide two elements in one leaf and leave another leaf stale. A restart in the middle of a sort shows whether leftover tree state leaks a second done strobe or a mixed result. Repeated sampling after done catches outputs that drift or done strobes that last longer than one cycle.

// File: rtl/tree_bubble_sorter.sv
`timescale 1ns/1ps
module tree_bubble_sorter #(
  parameter int P = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [P*W-1:0] data_i,
  output logic           done_o,
  output logic [P*W-1:0] sorted_o
);
  localparam int LG = $clog2(P);
  localparam int CW = LG + 1;
  localparam int N  = 2 * P;

  // leaves
  logic [W-1:0]  lval [P];
  logic          lv   [P];
  // inner cells: one slot per child side
  logic [W-1:0]  sl [1:P-1];
  logic [W-1:0]  sr [1:P-1];
  logic          vl [1:P-1];
  logic          vr [1:P-1];
  logic [CW-1:0] reml [1:P-1];
  logic [CW-1:0] remr [1:P-1];
  // offers, takes and gives
  logic          pick_l [1:P-1];
  logic          cv     [1:N-1];
  logic [W-1:0]  cval   [1:N-1];
  logic          tl     [1:P-1];
  logic          tr     [1:P-1];
  logic          gv     [1:N-1];
  // downward steering pipeline
  logic          dv    [LG];
  logic [W-1:0]  dval  [LG];
  logic [CW-1:0] dnode [LG];
  logic [CW-1:0] drank [LG];
  logic [CW-1:0] nn    [LG];
  logic [CW-1:0] nr    [LG];
  logic [CW-1:0] ecnt, wcnt;
  logic          emit;
  logic [W-1:0]  emit_val;

  function automatic logic [CW-1:0] half_leaves(input int n);
    int s, m;
    s = P;
    m = n;
    for (int k = 0; k < LG; k++)
      if (m > 1) begin
        m = m / 2;
        s = s / 2;
      end
    return CW'(s / 2);
  endfunction

  always_comb begin
    for (int n = 1; n < P; n++) begin
      pick_l[n] = vl[n] && (vr[n] ? (sl[n] <= sr[n]) : (remr[n] == '0));
      cv[n]     = pick_l[n] || (vr[n] && (vl[n] ? (sr[n] < sl[n]) : (reml[n] == '0)));
      cval[n]   = pick_l[n] ? sl[n] : sr[n];
    end
    for (int i = 0; i < P; i++) begin
      cv[P+i]   = lv[i];
      cval[P+i] = lval[i];
    end
    for (int n = 1; n < P; n++) begin
      tl[n] = !vl[n] && cv[2*n];
      tr[n] = !vr[n] && cv[2*n+1];
    end
    gv[1] = cv[1];
    for (int c = 2; c < N; c++)
      gv[c] = (c % 2 == 1) ? tr[c/2] : tl[c/2];
  end

  always_comb begin
    for (int k = 0; k < LG; k++) begin
      if (drank[k] <= CW'(P >> (k + 1))) begin
        nn[k] = CW'(dnode[k] << 1);
        nr[k] = drank[k];
      end else begin
        nn[k] = CW'(dnode[k] << 1) | CW'(1);
        nr[k] = drank[k] - CW'(P >> (k + 1));
      end
    end
  end

  assign emit     = cv[1];
  assign emit_val = cval[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) begin
        lv[i]   <= 1'b0;
        lval[i] <= '0;
      end
      for (int n = 1; n < P; n++) begin
        vl[n] <= 1'b0; vr[n] <= 1'b0;
        sl[n] <= '0;   sr[n] <= '0;
        reml[n] <= '0; remr[n] <= '0;
      end
      for (int k = 0; k < LG; k++) begin
        dv[k] <= 1'b0; dval[k] <= '0; dnode[k] <= '0; drank[k] <= '0;
      end
      ecnt     <= '0;
      wcnt     <= '0;
      done_o   <= 1'b0;
      sorted_o <= '0;
    end else if (load_i) begin
      for (int i = 0; i < P; i++) begin
        lv[i]   <= 1'b1;
        lval[i] <= data_i[i*W +: W];
      end
      for (int n = 1; n < P; n++) begin
        vl[n] <= 1'b0;
        vr[n] <= 1'b0;
        reml[n] <= half_leaves(n);
        remr[n] <= half_leaves(n);
      end
      for (int k = 0; k < LG; k++) dv[k] <= 1'b0;
      ecnt   <= '0;
      wcnt   <= '0;
      done_o <= 1'b0;
    end else begin
      for (int i = 0; i < P; i++)
        if (gv[P+i]) lv[i] <= 1'b0;
      for (int n = 1; n < P; n++) begin
        if (tl[n]) begin
          sl[n]   <= cval[2*n];
          vl[n]   <= 1'b1;
          reml[n] <= reml[n] - CW'(1);
        end else if (gv[n] && pick_l[n]) begin
          vl[n] <= 1'b0;
        end
        if (tr[n]) begin
          sr[n]   <= cval[2*n+1];
          vr[n]   <= 1'b1;
          remr[n] <= remr[n] - CW'(1);
        end else if (gv[n] && !pick_l[n]) begin
          vr[n] <= 1'b0;
        end
      end
      dv[0]    <= emit;
      dval[0]  <= emit_val;
      dnode[0] <= CW'(1);
      drank[0] <= ecnt + CW'(1);
      if (emit) ecnt <= ecnt + CW'(1);
      for (int k = 1; k < LG; k++) begin
        dv[k]    <= dv[k-1];
        dval[k]  <= dval[k-1];
        dnode[k] <= nn[k-1];
        drank[k] <= nr[k-1];
      end
      done_o <= 1'b0;
      if (dv[LG-1]) begin
        sorted_o[int'(nn[LG-1][LG-1:0])*W +: W] <= dval[LG-1];
        wcnt   <= wcnt + CW'(1);
        done_o <= (wcnt == CW'(P - 1));
      end
    end
  end
endmodule

// File: rtl/tree_bubble_sorter_chk.sv
`timescale 1ns/1ps
module tree_bubble_sorter_chk #(
  parameter int P  = 8,
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load_i,
  input logic           done_o,
  input logic [P*W-1:0] sorted_o,
  input logic           emit,
  input logic [W-1:0]   emit_val,
  input logic [CW-1:0]  ecnt,
  input logic [CW-1:0]  wcnt
);
  logic [W-1:0] last;
  logic         have;

  always_ff @(posedge clk) begin
    if (!rst_n || load_i) begin
      have <= 1'b0;
      last <= '0;
    end else if (emit) begin
      have <= 1'b1;
      last <= emit_val;
    end
  end

  AST_ROOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && have && !load_i) |-> (emit_val >= last)); // R2
  AST_EMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !load_i) |-> (ecnt < CW'(P))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (wcnt == CW'(P))); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> $stable(sorted_o)); // R5
endmodule

bind tree_bubble_sorter tree_bubble_sorter_chk #(.P(P), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .done_o(done_o), .sorted_o(sorted_o),
  .emit(emit), .emit_val(emit_val), .ecnt(ecnt), .wcnt(wcnt)
);

// File: tb/tree_bubble_sorter_tb.sv
`timescale 1ns/1ps
module tree_bubble_sorter_tb;
  localparam int P  = 8;
  localparam int W  = 8;
  localparam int LG = $clog2(P);
  localparam int LIMIT = 4*P + 2*LG + 8;
  typedef logic [P*W-1:0] vec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  vec_t data_i = '0;
  logic done_o;
  vec_t sorted_o;

  int checks = 0;
  int fails = 0;
  vec_t expq[$];
  string tagq[$];
  bit prev_done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  tree_bubble_sorter #(.P(P), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
    .done_o(done_o), .sorted_o(sorted_o)
  );

  function automatic vec_t sort_vec(input vec_t v);
    int a[P];
    int t;
    vec_t r;
    for (int i = 0; i < P; i++) a[i] = int'(v[i*W +: W]);
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P-1-i; j++)
        if (a[j] > a[j+1]) begin
          t = a[j]; a[j] = a[j+1]; a[j+1] = t;
        end
    for (int i = 0; i < P; i++) r[i*W +: W] = W'(a[i]);
    return r;
  endfunction

  function automatic vec_t rnd_vec(input logic [W-1:0] mask);
    vec_t r;
    for (int i = 0; i < P; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      r[i*W +: W] = W'(seed >> 16) & mask;
    end
    return r;
  endfunction

  // monitor: pops the scoreboard on every done strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        checks++;
        if (prev_done) begin
          fails++;
          $display("FAIL R4 done_o high two cycles: actual 1 expected 0");
        end
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R6 unexpected done_o: actual 1 expected 0");
        end else begin
          vec_t e;
          string tg;
          e  = expq.pop_front();
          tg = tagq.pop_front();
          if (sorted_o !== e) begin
            fails++;
            $display("FAIL %s sorted_o actual %h expected %h", tg, sorted_o, e);
          end
        end
      end
      prev_done = done_o;
    end
  end

  task automatic start_load(input vec_t v);
    @(negedge clk);
    data_i = v;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic run(input vec_t v, input string tag);
    vec_t e;
    int n;
    e = sort_vec(v);
    @(negedge clk);
    data_i = v;
    load_i = 1'b1;
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    load_i = 1'b0;
    n = 1;
    while (!done_o && n < LIMIT + 20) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!done_o || n > LIMIT) begin
      fails++;
      $display("FAIL R8 latency actual %0d expected <= %0d", n, LIMIT);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (sorted_o !== e) begin
      fails++;
      $display("FAIL R5 held output actual %h expected %h", sorted_o, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    checks++;
    if (done_o !== 1'b0 || sorted_o !== '0) begin
      fails++;
      $display("FAIL R1 reset state actual done=%b out=%h expected done=0 out=0", done_o, sorted_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle done actual %b expected 0", done_o);
    end

    // R2 ascending and descending
    for (int i = 0; i < P; i++) v[i*W +: W] = W'(i * 3 + 1);
    run(v, "R2");
    for (int i = 0; i < P; i++) v[i*W +: W] = W'(200 - i * 7);
    run(v, "R2");
    // R3 all equal and dense duplicates
    for (int i = 0; i < P; i++) v[i*W +: W] = W'(42);
    run(v, "R3");
    run(rnd_vec(W'(7)), "R3");
    run(rnd_vec(W'(3)), "R3");
    // R7 extremes
    for (int i = 0; i < P; i++) v[i*W +: W] = (i % 2 == 0) ? '1 : '0;
    run(v, "R7");
    for (int i = 0; i < P; i++) v[i*W +: W] = '1;
    v[5*W +: W] = '0;
    run(v, "R7");
    // R2 random
    for (int k = 0; k < 6; k++) run(rnd_vec('1), "R2");

    // R6 restart mid-sort: only the second vector may complete
    start_load(rnd_vec('1));
    repeat (4) @(negedge clk);
    run(rnd_vec('1), "R6");
    repeat (LIMIT + 10) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R6 pending results actual %0d expected 0", expq.size());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule